// File: doc/BRIEF.md
# Receive Descriptor Ring Writeback Engine

This block writes received frames into memory buffers that host software sets up. The host builds a ring of eight-word descriptors in a word-addressed memory and sets the ownership flag on each descriptor it hands over. When receive is started, the engine walks the ring from a programmed base address. It reads each descriptor's flag, size and buffer-address words and places an incoming byte stream into the descriptor's first buffer and then its second. It then writes one status word, which carries the length, the segment flags and the error flags, and which also hands the descriptor back to the host.

When the engine finds a descriptor that the host still owns, it suspends. Any frame that arrives while it is suspended is consumed and discarded, and a missed-frame counter counts it. A pulse on the poll-demand input makes the engine fetch the current descriptor again. A size-word flag marks the last descriptor of the ring, and after that descriptor the engine returns to the base address. Clearing the receive-start input stops the engine and moves its descriptor pointer back to the base.

Top module: `rx_ring_wb`

## Requirements
- R1: Right after reset the engine makes no memory access, holds `in_ready_o` low and reports zero missed frames.
- R2: The engine reads word 0 of the current descriptor. It treats the descriptor as its own only when bit 31 of that word is 1. It then reads word 1 (sizes), word 2 (buffer 1 byte address) and word 3 (buffer 2 byte address).
- R3: After a frame's last byte, the engine writes word 0 of the descriptor. In that word bit 31 is 0, bits 29:16 hold the count of bytes delivered, and bit 9 (first segment) and bit 8 (last segment) are both 1.
- R4: Frame bytes are packed little-endian into 32-bit words. They fill buffer 1 up to the length in size-word bits 12:0 and then buffer 2 up to the length in bits 28:16. Both lengths are counted in whole words, so bits 1:0 of each are ignored. A final partial word carries zero in its unused upper bytes.
- R5: Bytes beyond the combined buffer capacity are not written. The status word then has bit 11 (overflow) and bit 15 (error summary) set, and its length field still counts every byte delivered.
- R6: When bit 15 of the size word is 1, the next descriptor is the one at the ring base. Otherwise it is the descriptor 32 bytes further on.
- R7: A CRC error flagged with the last byte sets status bit 1 and bit 15. A frame-type flag given with the last byte sets status bit 5, and the length then includes the 4 trailing CRC bytes of the stream.
- R8: On a host-owned descriptor the engine suspends. While suspended it accepts and discards any arriving frame, makes no memory write, and raises the missed-frame count by one when the dropped frame's last byte is accepted.
- R9: A one-cycle pulse on `poll_i` while suspended makes the engine fetch the same descriptor again. The engine does the same by itself after it drops a frame.
- R10: While `start_i` is low, the engine stays idle with `in_ready_o` low and its descriptor pointer equal to the base address. Receive therefore starts again at the ring base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Receive start; low stops the engine and resets its pointer |
| poll_i | input | 1 | Poll-demand pulse |
| base_addr_i | input | AW+2 | Ring base byte address (word aligned) |
| in_valid_i | input | 1 | Stream byte valid |
| in_data_i | input | 8 | Stream byte |
| in_last_i | input | 1 | Marks the last byte of a frame |
| in_crc_err_i | input | 1 | CRC error flag, sampled with the last byte |
| in_ftype_i | input | 1 | Frame-type flag, sampled with the last byte |
| in_ready_o | output | 1 | Engine accepts a byte this cycle |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Write when 1, read when 0 |
| mem_addr_o | output | AW | Memory word address |
| mem_wdata_o | output | 32 | Write data |
| mem_rdata_i | input | 32 | Read data, one cycle after the read request |
| missed_cnt_o | output | CNT_W | Frames dropped while suspended |

## Verification
Each descriptor word the engine reads arrives one cycle after its request. A byte stream can therefore start five cycles after the flag fetch, and the bench handshakes every byte on `in_ready_o` instead of assuming that start time. A data word is written at the edge that accepts its fourth byte, or the frame's last byte. The status word follows one cycle after the last byte, and the missed count moves at the edge that accepts a dropped frame's last byte. The bench compares descriptor memory and the counter only after a settling gap of twelve cycles. It also checks every write cycle by cycle against the set of addresses the model allows, and it allows none while a frame is being dropped.

// File: rtl/rx_wb_pkg.sv
package rx_wb_pkg;
  localparam int unsigned DESC_WORDS = 8;
  localparam int unsigned OWN_BIT    = 31;
  localparam int unsigned ERR_SUM    = 15;
  localparam int unsigned OVF_BIT    = 11;
  localparam int unsigned FIRST_BIT  = 9;
  localparam int unsigned LAST_BIT   = 8;
  localparam int unsigned FTYPE_BIT  = 5;
  localparam int unsigned CRC_BIT    = 1;
  localparam int unsigned LEN_LSB    = 16;
  localparam int unsigned LEN_W      = 14;

  typedef enum logic [3:0] {
    S_IDLE, S_RD_FLG, S_CHK, S_RD_A1, S_RD_A2, S_CAP,
    S_RECV, S_WB, S_SUSP, S_DROP
  } rx_state_e;
endpackage

// File: rtl/rx_ring_ptr.sv
module rx_ring_ptr #(
  parameter int unsigned AW = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clear_i,
  input  logic          advance_i,
  input  logic          wrap_i,
  input  logic [AW-1:0] base_i,
  output logic [AW-1:0] ptr_o
);
  import rx_wb_pkg::*;
  localparam logic [AW-1:0] STRIDE = AW'(DESC_WORDS);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        ptr_o <= '0;
    else if (clear_i)   ptr_o <= base_i;
    else if (advance_i) ptr_o <= wrap_i ? base_i : ptr_o + STRIDE;
  end

  AST_WRAP_TO_BASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (advance_i && wrap_i && !clear_i) |=> (ptr_o == $past(base_i))); // R6
  AST_STEP_NEXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (advance_i && !wrap_i && !clear_i) |=> (ptr_o == $past(ptr_o) + STRIDE)); // R6
  AST_STOP_BASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (ptr_o == $past(base_i))); // R10
endmodule

// File: rtl/rx_byte_packer.sv
module rx_byte_packer #(
  parameter int unsigned AW = 10,
  parameter int unsigned CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          frame_start_i,
  input  logic          accept_i,
  input  logic          last_i,
  input  logic [7:0]    data_i,
  input  logic [AW-1:0] buf1_i,
  input  logic [AW-1:0] buf2_i,
  input  logic [10:0]   l1w_i,
  input  logic [10:0]   l2w_i,
  output logic          we_o,
  output logic [AW-1:0] addr_o,
  output logic [31:0]   wdata_o,
  output logic [13:0]   len_o,
  output logic          ovf_o
);
  localparam int unsigned WW = CW - 2;

  logic [CW-1:0] cnt_q;
  logic [31:0]   acc_q;
  logic [1:0]    pos;
  logic [WW-1:0] widx, cap_w, l1_ext, off;
  logic          in_b1, in_room;

  assign pos     = cnt_q[1:0];
  assign widx    = cnt_q[CW-1:2];
  assign l1_ext  = WW'(l1w_i);
  assign cap_w   = l1_ext + WW'(l2w_i);
  assign in_room = widx < cap_w;
  assign in_b1   = widx < l1_ext;
  assign off     = in_b1 ? widx : widx - l1_ext;
  assign addr_o  = (in_b1 ? buf1_i : buf2_i) + off[AW-1:0];
  assign we_o    = accept_i && in_room && (pos == 2'd3 || last_i);
  assign len_o   = cnt_q[13:0];

  for (genvar b = 0; b < 4; b++) begin : g_byte
    assign wdata_o[8*b +: 8] = (2'(b) < pos)  ? acc_q[8*b +: 8] :
                               (2'(b) == pos) ? data_i : 8'h00;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      acc_q <= '0;
      ovf_o <= 1'b0;
    end else if (frame_start_i) begin
      cnt_q <= '0;
      ovf_o <= 1'b0;
    end else if (accept_i) begin
      acc_q[8*pos +: 8] <= data_i;
      cnt_q <= cnt_q + 1'b1;
      if (!in_room) ovf_o <= 1'b1;
    end
  end

  AST_OVF_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_o && !frame_start_i) |=> ovf_o); // R5
  AST_LEN_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept_i && !frame_start_i) |=> (len_o == $past(len_o) + 14'd1)); // R3
endmodule

// File: rtl/rx_status_fmt.sv
module rx_status_fmt (
  input  logic [13:0] len_i,
  input  logic        ovf_i,
  input  logic        crc_i,
  input  logic        ftype_i,
  output logic [31:0] word_o
);
  import rx_wb_pkg::*;
  always_comb begin
    word_o = '0;
    word_o[LEN_LSB +: LEN_W] = len_i;
    word_o[ERR_SUM]   = ovf_i | crc_i;
    word_o[OVF_BIT]   = ovf_i;
    word_o[FIRST_BIT] = 1'b1;
    word_o[LAST_BIT]  = 1'b1;
    word_o[FTYPE_BIT] = ftype_i;
    word_o[CRC_BIT]   = crc_i;
    word_o[OWN_BIT]   = 1'b0;
  end
endmodule

// File: rtl/rx_ring_wb.sv
module rx_ring_wb #(
  parameter int unsigned AW    = 10,
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             poll_i,
  input  logic [AW+1:0]    base_addr_i,
  input  logic             in_valid_i,
  input  logic [7:0]       in_data_i,
  input  logic             in_last_i,
  input  logic             in_crc_err_i,
  input  logic             in_ftype_i,
  output logic             in_ready_o,
  output logic             mem_req_o,
  output logic             mem_we_o,
  output logic [AW-1:0]    mem_addr_o,
  output logic [31:0]      mem_wdata_o,
  input  logic [31:0]      mem_rdata_i,
  output logic [CNT_W-1:0] missed_cnt_o
);
  import rx_wb_pkg::*;

  rx_state_e     state_q, state_d;
  logic [AW-1:0] ptr, a1_q, a2_q;
  logic [10:0]   l1w_q, l2w_q;
  logic          end_q, crc_q, ft_q;
  logic          accept, advance, miss_inc;
  logic          pk_we, pk_ovf;
  logic [AW-1:0] pk_addr;
  logic [31:0]   pk_wdata, status;
  logic [13:0]   pk_len;
  logic          unused_bits;

  assign unused_bits = ^{mem_rdata_i, base_addr_i[1:0]};

  rx_ring_ptr #(.AW(AW)) u_ptr (
    .clk_i, .rst_ni, .clear_i(!start_i), .advance_i(advance), .wrap_i(end_q),
    .base_i(base_addr_i[AW+1:2]), .ptr_o(ptr)
  );

  rx_byte_packer #(.AW(AW), .CW(16)) u_pack (
    .clk_i, .rst_ni, .frame_start_i(state_q == S_CAP), .accept_i(accept),
    .last_i(in_last_i), .data_i(in_data_i), .buf1_i(a1_q), .buf2_i(a2_q),
    .l1w_i(l1w_q), .l2w_i(l2w_q), .we_o(pk_we), .addr_o(pk_addr),
    .wdata_o(pk_wdata), .len_o(pk_len), .ovf_o(pk_ovf)
  );

  rx_status_fmt u_fmt (
    .len_i(pk_len), .ovf_i(pk_ovf), .crc_i(crc_q), .ftype_i(ft_q), .word_o(status)
  );

  always_comb begin
    state_d     = state_q;
    mem_req_o   = 1'b0;
    mem_we_o    = 1'b0;
    mem_addr_o  = ptr;
    mem_wdata_o = status;
    in_ready_o  = 1'b0;
    accept      = 1'b0;
    advance     = 1'b0;
    miss_inc    = 1'b0;
    unique case (state_q)
      S_IDLE:   state_d = S_RD_FLG;
      S_RD_FLG: begin mem_req_o = 1'b1; state_d = S_CHK; end
      S_CHK: begin
        if (mem_rdata_i[OWN_BIT]) begin
          mem_req_o  = 1'b1;
          mem_addr_o = ptr + AW'(1);
          state_d    = S_RD_A1;
        end else state_d = S_SUSP;
      end
      S_RD_A1: begin mem_req_o = 1'b1; mem_addr_o = ptr + AW'(2); state_d = S_RD_A2; end
      S_RD_A2: begin mem_req_o = 1'b1; mem_addr_o = ptr + AW'(3); state_d = S_CAP; end
      S_CAP:    state_d = S_RECV;
      S_RECV: begin
        in_ready_o  = 1'b1;
        accept      = in_valid_i;
        mem_req_o   = pk_we;
        mem_we_o    = pk_we;
        mem_addr_o  = pk_addr;
        mem_wdata_o = pk_wdata;
        if (in_valid_i && in_last_i) state_d = S_WB;
      end
      S_WB: begin
        mem_req_o = 1'b1;
        mem_we_o  = 1'b1;
        advance   = 1'b1;
        state_d   = S_RD_FLG;
      end
      S_SUSP: begin
        in_ready_o = 1'b1;
        if (in_valid_i) begin
          if (in_last_i) begin miss_inc = 1'b1; state_d = S_RD_FLG; end
          else state_d = S_DROP;
        end else if (poll_i) state_d = S_RD_FLG;
      end
      S_DROP: begin
        in_ready_o = 1'b1;
        if (in_valid_i && in_last_i) begin miss_inc = 1'b1; state_d = S_RD_FLG; end
      end
      default: state_d = S_IDLE;
    endcase
    if (!start_i) begin
      state_d    = S_IDLE;
      mem_req_o  = 1'b0;
      mem_we_o   = 1'b0;
      in_ready_o = 1'b0;
      accept     = 1'b0;
      advance    = 1'b0;
      miss_inc   = 1'b0;
    end else if (state_q == S_IDLE) begin
      state_d = S_RD_FLG;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= S_IDLE;
      l1w_q        <= '0;
      l2w_q        <= '0;
      end_q        <= 1'b0;
      a1_q         <= '0;
      a2_q         <= '0;
      crc_q        <= 1'b0;
      ft_q         <= 1'b0;
      missed_cnt_o <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == S_RD_A1) begin
        l1w_q <= mem_rdata_i[12:2];
        l2w_q <= mem_rdata_i[28:18];
        end_q <= mem_rdata_i[15];
      end
      if (state_q == S_RD_A2) a1_q <= mem_rdata_i[AW+1:2];
      if (state_q == S_CAP)   a2_q <= mem_rdata_i[AW+1:2];
      if (accept && in_last_i) begin
        crc_q <= in_crc_err_i;
        ft_q  <= in_ftype_i;
      end
      if (miss_inc) missed_cnt_o <= missed_cnt_o + 1'b1;
    end
  end

  AST_WB_RELEASES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o && state_q == S_WB) |-> !mem_wdata_o[OWN_BIT]); // R3
  AST_NO_WRITE_SUSP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_SUSP || state_q == S_DROP) |-> !mem_we_o); // R8
  AST_MISS_ON_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (missed_cnt_o != $past(missed_cnt_o)) |->
      $past(in_valid_i && in_last_i && in_ready_o)); // R8
  AST_STOP_NOT_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> !in_ready_o); // R10
  AST_RECV_AFTER_FETCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(state_q == S_RECV) |-> $past(state_q == S_CAP)); // R2
endmodule

// File: tb/rx_ring_wb_tb.sv
module rx_ring_wb_tb;
  localparam int CLK_P = 10;
  localparam int AW = 10;
  localparam logic [31:0] SENT = 32'hDEAD_BEEF;

  logic clk = 0, rst_n = 0, start = 0, poll = 0;
  logic in_valid = 0, in_last = 0, in_crc = 0, in_ft = 0;
  logic [7:0] in_data = 0;
  logic in_ready, mem_req, mem_we;
  logic [AW-1:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata;
  logic [15:0] missed;
  logic host_we = 0;
  logic [AW-1:0] host_addr = 0;
  logic [31:0] host_data = 0;
  logic no_write = 0;
  logic [31:0] mem [0:1023];
  int checks = 0, fails = 0;

  always #(CLK_P/2) clk = ~clk;

  rx_ring_wb #(.AW(AW), .CNT_W(16)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .poll_i(poll),
    .base_addr_i(12'h000), .in_valid_i(in_valid), .in_data_i(in_data),
    .in_last_i(in_last), .in_crc_err_i(in_crc), .in_ftype_i(in_ft),
    .in_ready_o(in_ready), .mem_req_o(mem_req), .mem_we_o(mem_we),
    .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata),
    .missed_cnt_o(missed)
  );

  always @(posedge clk) begin
    if (host_we) mem[host_addr] <= host_data;
    if (mem_req && mem_we) mem[mem_addr] <= mem_wdata;
    if (mem_req && !mem_we) mem_rdata <= mem[mem_addr];
  end

  function automatic bit allowed(input int a);
    if (a < 32) return (a % 8) == 0;
    if (a >= 256 && a < 768) return ((a - 256) % 32) < 4;
    return 0;
  endfunction

  // model of legal write targets, compared on every clock
  always @(negedge clk) begin
    if (rst_n && mem_req && mem_we) begin
      checks++;
      if (no_write || !allowed(int'(mem_addr))) begin
        fails++;
        $display("FAIL R8/R4 write addr=%0d act=write exp=%s", mem_addr,
                 no_write ? "none" : "buffer/status only");
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic host_wr(input int a, input logic [31:0] d);
    @(negedge clk);
    host_we = 1; host_addr = AW'(a); host_data = d;
    @(posedge clk); #1;
    host_we = 0;
  endtask

  task automatic arm(input int d, input bit own);
    host_wr(8*d,     own ? 32'h8000_0000 : 32'h0);
    host_wr(8*d + 1, 32'h0010_0010 | (d == 3 ? 32'h8000 : 32'h0));
    host_wr(8*d + 2, 32'h400 + 32'h80 * d);
    host_wr(8*d + 3, 32'h800 + 32'h80 * d);
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input int n, input logic [7:0] seed, input logic crc, input logic ft);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      in_valid = 1; in_data = 8'(seed + k); in_last = (k == n - 1);
      in_crc = crc && in_last; in_ft = ft && in_last;
      while (!in_ready) @(negedge clk);
      @(posedge clk); #1;
      in_valid = 0; in_last = 0; in_crc = 0; in_ft = 0;
    end
    wait_cyc(12);
  endtask

  function automatic logic [31:0] exp_stat(input int n, input bit crc, input bit ft);
    bit ovf = n > 32;
    return (32'(n & 16'h3fff) << 16) | ((ovf || crc) ? 32'h8000 : 0) |
           (ovf ? 32'h800 : 0) | 32'h300 | (ft ? 32'h20 : 0) | (crc ? 32'h2 : 0);
  endfunction

  task automatic check_frame(input string tag, input int d, input int n,
                             input logic [7:0] seed, input bit crc, input bit ft);
    int nw = (n + 3) / 4;
    if (nw > 8) nw = 8;
    chk({tag, " status"}, mem[8*d], exp_stat(n, crc, ft));
    for (int w = 0; w < nw; w++) begin
      logic [31:0] e = 0;
      int a = (w < 4) ? 256 + 32*d + w : 512 + 32*d + w - 4;
      for (int b = 0; b < 4; b++)
        if (4*w + b < n) e[8*b +: 8] = 8'(seed + 4*w + b);
      chk({tag, " data"}, mem[a], e);
    end
    if (n <= 16) chk({tag, " buf2 untouched"}, mem[512 + 32*d], SENT);
    if (n > 32)  chk({tag, " beyond capacity"}, mem[512 + 32*d + 4], SENT);
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = SENT;
    wait_cyc(3);
    chk("R1 req", {31'b0, mem_req}, 0);
    chk("R1 ready", {31'b0, in_ready}, 0);
    rst_n = 1;
    wait_cyc(2);
    chk("R1 missed", {16'b0, missed}, 0);
    chk("R1 idle req", {31'b0, mem_req}, 0);
    for (int d = 0; d < 4; d++) arm(d, 1);
    @(negedge clk); start = 1;

    send(10, 8'h10, 0, 0);
    check_frame("R2 R3 R4 single buffer", 0, 10, 8'h10, 0, 0);
    send(24, 8'h40, 0, 0);
    check_frame("R4 split buffers", 1, 24, 8'h40, 0, 0);
    send(40, 8'h80, 0, 0);
    check_frame("R5 overflow", 2, 40, 8'h80, 0, 0);
    send(8, 8'hC0, 1, 1);
    check_frame("R7 crc and frame type", 3, 8, 8'hC0, 1, 1);

    // wrapped to desc 0, host-owned now: frame dropped
    no_write = 1;
    send(6, 8'h20, 0, 0);
    no_write = 0;
    chk("R8 missed after drop", {16'b0, missed}, 1);
    check_frame("R8 desc0 unchanged", 0, 10, 8'h10, 0, 0);

    arm(0, 1);
    @(negedge clk); poll = 1;
    @(negedge clk); poll = 0;
    send(5, 8'h55, 0, 0);
    check_frame("R6 R9 wrap then poll", 0, 5, 8'h55, 0, 0);
    chk("R9 missed stable", {16'b0, missed}, 1);

    // poll with desc1 still host-owned: re-fetch, suspend again
    @(negedge clk); poll = 1;
    @(negedge clk); poll = 0;
    wait_cyc(8);
    no_write = 1;
    send(3, 8'h33, 0, 0);
    no_write = 0;
    chk("R9 poll on host-owned", {16'b0, missed}, 2);

    @(negedge clk); start = 0;
    @(negedge clk);
    chk("R10 ready low when stopped", {31'b0, in_ready}, 0);
    for (int d = 0; d < 4; d++) arm(d, 1);
    @(negedge clk); start = 1;
    send(12, 8'h70, 0, 0);
    check_frame("R10 restart at base", 0, 12, 8'h70, 0, 0);
    chk("R10 desc1 still owned", mem[8], 32'h8000_0000);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule